// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Target

This block is a target on a two-wire serial bus (I2C) that fronts a 256-byte internal memory. A bus controller writes single bytes or runs of bytes into the memory. It can read back in three ways: from wherever the internal pointer currently stands, from a location it names first, or as an unbroken stream that continues while it keeps acknowledging.

Both bus lines are sampled into the system clock domain through two-flop synchronizers. Start and stop conditions and clock edges are found there, and all decisions are taken on the detected clock edges. The data line is modelled as an input plus an open-drain pull-low enable. The target changes that enable only while the bus clock is low. A single byte pointer serves reads and writes. Writes roll over within a 16-byte page. Reads roll over across the whole memory.

Top module: `i2c_mem_target`

## Requirements
- R1: A header byte whose upper 7 bits equal DEV_ADDR (default 7'h50) gets an ACK, meaning SDA pulled low for the 9th clock. On a mismatch nothing is acknowledged, and following bytes neither get an ACK nor change the memory until the next START.
- R2: A header with bit 0 = 1 (read) returns the byte at the current pointer, MSB first, starting right after the ACK.
- R3: A header with bit 0 = 0, one pointer byte and then a repeated START with a read header returns the byte at that pointer value.
- R4: While the controller ACKs a read byte (SDA low on the 9th clock), the next location is sent. After a NACK (SDA high) the target releases SDA and sends nothing more.
- R5: The read pointer advances by one per byte sent and rolls over from 0xFF to 0x00.
- R6: A write header, a pointer byte and a data byte store that data at that pointer, and each of those bytes gets an ACK.
- R7: During multi-byte writes only the low 4 pointer bits advance, so the pointer rolls from the end of a 16-byte page to that page's first byte.
- R8: A pointer byte followed directly by STOP only loads the pointer and writes nothing. A later read without a pointer returns the byte at the loaded location.
- R9: After a read byte, the pointer already names the next location, so a following current-pointer read returns it.
- R10: A START at any point, including inside a data byte, discards the partial byte and begins a new header. A STOP returns the target to idle with SDA released.
- R11: The pull-low enable changes only while SCL is low.
- R12: During and after reset the pull-low enable is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_pull_o | output | 1 | Open-drain enable; 1 pulls the data line low |

## Verification
A wrong bit counter or state shows up within one byte time: an ACK lands in the wrong clock slot, or a read byte comes out shifted. A wrong pointer stays hidden until the next read. It then returns data from the wrong location, so each write run is followed by reads that land on the page rollover, the memory rollover and a pointer-only transfer. A mid-byte START and an address mismatch are each followed by a read. That read would expose a stray write straight away.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WORD,
    ST_WRITE,
    ST_READ
  } tgt_state_e;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_d,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_byte_mem.sv
module i2c_byte_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2c_mem_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         AW          = 8,
  parameter int         PAGE_W      = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o
);
  localparam logic [3:0] LAST_BIT = 4'd8;
  localparam logic [3:0] ACK_SLOT = 4'd9;

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic scl_s, sda_s, scl_d, scl_rise, scl_fall, start_p, stop_p;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_d(scl_d), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p)
  );

  tgt_state_e    st_q, st_n;
  logic [3:0]    cnt_q, cnt_n;
  logic [7:0]    sh_q, sh_n, tx_q, tx_n;
  logic [AW-1:0] addr_q, addr_n;
  logic          rw_q, rw_n, mack_q, mack_n, pull_q, pull_n;
  logic          mem_we;
  logic [7:0]    rd_data;

  i2c_byte_mem #(.AW(AW), .DW(8)) u_mem (
    .clk(clk), .we(mem_we), .waddr(addr_q), .wdata(sh_q),
    .raddr(addr_q), .rdata(rd_data)
  );

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    tx_n   = tx_q;
    addr_n = addr_q;
    rw_n   = rw_q;
    mack_n = mack_q;
    pull_n = pull_q;
    mem_we = 1'b0;
    if (start_p) begin
      st_n   = ST_DEV;
      cnt_n  = '0;
      pull_n = 1'b0;
    end else if (stop_p) begin
      st_n   = ST_IDLE;
      cnt_n  = '0;
      pull_n = 1'b0;
    end else begin
      unique case (st_q)
        ST_DEV, ST_WORD, ST_WRITE: begin
          if (scl_rise) begin
            if (cnt_q < LAST_BIT) begin
              sh_n  = {sh_q[6:0], sda_s};
              cnt_n = cnt_q + 4'd1;
            end else begin
              cnt_n = ACK_SLOT;
            end
          end else if (scl_fall && cnt_q == LAST_BIT) begin
            if (st_q == ST_DEV) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                pull_n = 1'b1;
                rw_n   = sh_q[0];
              end else begin
                st_n = ST_IDLE;
              end
            end else if (st_q == ST_WORD) begin
              pull_n = 1'b1;
              addr_n = sh_q[AW-1:0];
            end else begin
              pull_n = 1'b1;
              mem_we = 1'b1;
              addr_n = {addr_q[AW-1:PAGE_W], addr_q[PAGE_W-1:0] + 1'b1};
            end
          end else if (scl_fall && cnt_q == ACK_SLOT) begin
            pull_n = 1'b0;
            cnt_n  = '0;
            if (st_q == ST_DEV && rw_q) begin
              st_n   = ST_READ;
              tx_n   = rd_data;
              pull_n = ~rd_data[7];
            end else if (st_q == ST_DEV) begin
              st_n = ST_WORD;
            end else begin
              st_n = ST_WRITE;
            end
          end
        end
        ST_READ: begin
          if (scl_rise) begin
            if (cnt_q < LAST_BIT) begin
              cnt_n = cnt_q + 4'd1;
            end else begin
              cnt_n  = ACK_SLOT;
              mack_n = ~sda_s;
            end
          end else if (scl_fall) begin
            if (cnt_q < LAST_BIT) begin
              pull_n = ~tx_q[3'(4'd7 - cnt_q)];
            end else if (cnt_q == LAST_BIT) begin
              pull_n = 1'b0;
              addr_n = addr_q + 1'b1;
            end else if (mack_q) begin
              tx_n   = rd_data;
              pull_n = ~rd_data[7];
              cnt_n  = '0;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      addr_q <= '0;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
      pull_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      tx_q   <= tx_n;
      addr_q <= addr_n;
      rw_q   <= rw_n;
      mack_q <= mack_n;
      pull_q <= pull_n;
    end
  end

  assign sda_pull_o = pull_q;
endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk
  import i2c_mem_pkg::*;
#(
  parameter int AW     = 8,
  parameter int PAGE_W = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_d,
  input logic          scl_fall,
  input logic          start_p,
  input logic          stop_p,
  input logic          pull,
  input tgt_state_e    st,
  input logic [3:0]    cnt,
  input logic          mem_we,
  input logic [AW-1:0] addr
);
  // R11
  pull_steady_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_d |-> $stable(pull));

  // R1
  idle_no_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !pull);

  // R10
  start_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> (st == ST_DEV && cnt == 4'd0 && !pull));

  // R10
  stop_idles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_p && !start_p) |=> (st == ST_IDLE && !pull));

  // R7
  page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (addr[AW-1:PAGE_W] == $past(addr[AW-1:PAGE_W]) &&
                addr[PAGE_W-1:0] == $past(addr[PAGE_W-1:0]) + 1'b1));

  // R5
  read_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_READ && scl_fall && cnt == 4'd8 && !start_p && !stop_p)
      |=> addr == $past(addr) + 1'b1);

  // R1
  bit_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 4'd9);
endmodule

bind i2c_mem_target i2c_mem_target_chk #(.AW(AW), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .scl_d(scl_d), .scl_fall(scl_fall),
  .start_p(start_p), .stop_p(stop_p), .pull(pull_q), .st(st_q),
  .cnt(cnt_q), .mem_we(mem_we), .addr(addr_q)
);

// File: tb/i2c_mem_target_tb.sv
module i2c_mem_target_tb;
  localparam int Q = 8;

  logic clk, rst_n, scl_m, sda_m, sda_pull, sda_bus;
  assign sda_bus = sda_m & ~sda_pull;

  i2c_mem_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;

  exp_t       exp_q[$];
  int         n_cmp = 0;
  int         n_bad = 0;
  int         r11_viol = 0;
  logic [7:0] got;
  event       got_ev;
  bit         done = 0;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(got_ev);
    if (exp_q.size() == 0) begin
      n_cmp++;
      n_bad++;
      $display("FAIL unexpected byte: act=%0h exp=none", got);
    end else begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.tag, {24'd0, got}, {24'd0, e.val});
    end
  end

  // R11: pull enable must not move while SCL is high
  logic pull_prev, scl_prev;
  always @(negedge clk) begin
    if (rst_n && scl_m && scl_prev && sda_pull !== pull_prev) r11_viol++;
    pull_prev <= sda_pull;
    scl_prev  <= scl_m;
  end

  task automatic bus_start;
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_rstart;
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic write_bit(input logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic read_bit(output logic b);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); b = sda_bus; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send(input logic [7:0] b, input logic exp_ack, input string tag);
    logic a;
    for (int i = 7; i >= 0; i--) write_bit(b[i]);
    read_bit(a);
    check(tag, {31'd0, ~a}, {31'd0, exp_ack});
  endtask

  task automatic recv(input logic ack, input logic [7:0] expv, input string tag);
    logic [7:0] d;
    exp_q.push_back('{expv, tag});
    for (int i = 7; i >= 0; i--) read_bit(d[i]);
    got = d;
    ->got_ev;
    write_bit(~ack);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: act=hung exp=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    tick(5);
    check("R12 pull in reset", {31'd0, sda_pull}, 0);
    rst_n = 1'b1;
    tick(10);
    check("R12 pull after reset", {31'd0, sda_pull}, 0);

    // R6 single byte write to 0x40
    bus_start; send(8'hA0, 1, "R1 header ack"); send(8'h40, 1, "R6 ptr ack");
    send(8'h5A, 1, "R6 data ack"); bus_stop;

    // R7 run of four from 0x1E wraps to 0x10
    bus_start; send(8'hA0, 1, "R7"); send(8'h1E, 1, "R7");
    send(8'hB0, 1, "R7"); send(8'hB1, 1, "R7");
    send(8'hB2, 1, "R7"); send(8'hB3, 1, "R7"); bus_stop;

    // fill memory top and bottom for rollover reads
    bus_start; send(8'hA0, 1, "R6"); send(8'hFE, 1, "R6");
    send(8'hC1, 1, "R6"); send(8'hC2, 1, "R6"); bus_stop;
    bus_start; send(8'hA0, 1, "R6"); send(8'h00, 1, "R6");
    send(8'hC3, 1, "R6"); bus_stop;

    // R3 random read then R4 continued read, then NACK
    bus_start; send(8'hA0, 1, "R3"); send(8'h1E, 1, "R3"); bus_rstart;
    send(8'hA1, 1, "R3 read header ack");
    recv(1, 8'hB0, "R3 random read 0x1E");
    recv(0, 8'hB1, "R4 continued read 0x1F");
    check("R4 released after NACK", {31'd0, sda_pull}, 0);
    bus_stop;

    // R7 wrap landed in 0x10/0x11; R9 pointer advanced
    bus_start; send(8'hA0, 1, "R3"); send(8'h10, 1, "R3"); bus_rstart;
    send(8'hA1, 1, "R3");
    recv(0, 8'hB2, "R7 wrapped byte at 0x10"); bus_stop;
    bus_start; send(8'hA1, 1, "R2");
    recv(0, 8'hB3, "R9 next location 0x11"); bus_stop;

    // R5 read rollover 0xFF -> 0x00
    bus_start; send(8'hA0, 1, "R5"); send(8'hFE, 1, "R5"); bus_rstart;
    send(8'hA1, 1, "R5");
    recv(1, 8'hC1, "R5 0xFE"); recv(1, 8'hC2, "R5 0xFF");
    recv(0, 8'hC3, "R5 rolled to 0x00"); bus_stop;

    // R8 pointer-only write then R2 current-pointer read
    bus_start; send(8'hA0, 1, "R8"); send(8'h40, 1, "R8"); bus_stop;
    bus_start; send(8'hA1, 1, "R2");
    recv(0, 8'h5A, "R8 R2 current read at loaded ptr"); bus_stop;

    // R1 wrong address: no ACKs, no write
    bus_start; send(8'h42, 0, "R1 mismatch header");
    send(8'h40, 0, "R1 ignored byte"); send(8'hFF, 0, "R1 ignored byte");
    bus_stop;
    bus_start; send(8'hA0, 1, "R1"); send(8'h40, 1, "R1"); bus_rstart;
    send(8'hA1, 1, "R1");
    recv(0, 8'h5A, "R1 memory untouched by mismatch"); bus_stop;

    // R10 START inside a data byte
    bus_start; send(8'hA0, 1, "R10"); send(8'h10, 1, "R10");
    write_bit(1'b1); write_bit(1'b0); write_bit(1'b1); write_bit(1'b0);
    bus_rstart; send(8'hA1, 1, "R10 header after mid-byte START");
    recv(0, 8'hB2, "R10 partial byte not written"); bus_stop;
    tick(Q);
    check("R10 idle after STOP", {31'd0, sda_pull}, 0);

    check("R11 pull moved while SCL high", r11_viol, 0);
    tick(10);
    check("R2 R4 all expected bytes seen", exp_q.size(), 0);
    done = 1;
    finish_run();
  end
endmodule